// File: doc/BRIEF.md
# Leveled Interrupt Pending and Priority Resolver

This block keeps the pending state of interrupt sources grouped into priority levels. Each level has a wide vector of sub-sources. A per-level status word records which levels have work outstanding. The state changes through post commands, clear commands and a clear-all command. Software interrupt requests arrive as a mask input, and the current interrupt priority level arrives as a number.

Every cycle the block maps the software requests and the external level status into one priority space. Each kind of request has its own encoding. The block then picks the winning priority and builds a summary mask of the active bits. When the winner is above the current level, a registered take pulse fires, and the summary register and the interrupt ID register load together on the same edge. A nonzero asynchronous trap request is not supported: it raises an error pulse instead of being resolved. A post or clear aimed outside the stored range also raises an error pulse.

Top module: `irq_level_resolver`

## Requirements
- R1: A legal post (level < 32, index < 64) sets that sub-source bit, and on the next clock edge the level's bit in `level_status` reads 1.
- R2: A legal clear drops one sub-source bit. The level's status bit returns to 0 only once every sub-source of that level is clear; while any other posted bit remains, it stays 1.
- R3: Synchronous reset and `clr_all` both zero every level vector and `level_status`. `clr_all` overrides a post or clear in the same cycle. After reset, `irq_taken`, `isr_q`, `intid_q`, `cmd_err` and `ast_err` are all 0.
- R4: A post or clear whose level is 32 or more, or whose index is 64 or more, changes no state, and `cmd_err` pulses high for one cycle after the command.
- R5: Bit i of `sw_req` counts only for i in 1 to 15, where it gives priority (i − 1) + 1 and sets bit i of the summary. Bit 0 and bits 16 to 31 of `sw_req` are ignored.
- R6: Bit i of `level_status` counts only for i in 16 to 31, where it gives priority i and sets bit i of the summary. Levels 0 to 15 never contribute.
- R7: The resolved priority is the highest one found, so any active external level beats every software request. The summary mask holds every contributing bit from both ranges.
- R8: One cycle after the inputs are presented, `irq_taken` is 1 exactly when the resolved priority is nonzero and strictly greater than `cur_ipl`. On that edge `isr_q` loads the summary and `intid_q` loads the priority. Otherwise both registers hold their values.
- R9: When `ast_req` is nonzero, the next cycle shows `ast_err` = 1 and `irq_taken` = 0.
- R10: A post and a clear that hit the same bit in the same cycle leave that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_v | input | 1 | Post command valid |
| post_lvl | input | 6 | Post target level |
| post_idx | input | 7 | Post target sub-source index |
| clr_v | input | 1 | Clear command valid |
| clr_lvl | input | 6 | Clear target level |
| clr_idx | input | 7 | Clear target sub-source index |
| clr_all | input | 1 | Zero all pending state |
| sw_req | input | 32 | Software interrupt request mask |
| cur_ipl | input | 5 | Current interrupt priority level |
| ast_req | input | 4 | Asynchronous trap request (unsupported when nonzero) |
| level_status | output | 32 | Per-level pending summary |
| irq_taken | output | 1 | Registered interrupt-taken pulse |
| isr_q | output | 32 | Interrupt summary register |
| intid_q | output | 5 | Interrupt ID register |
| cmd_err | output | 1 | Illegal post/clear pulse |
| ast_err | output | 1 | Asynchronous trap request error pulse |

## Verification
The hardest case to reach from the ports is a level status bit that must stay set while some, but not all, of its sub-sources are cleared. The only evidence is the single summary bit for that level. The stimulus posts two far-apart indices in one level and clears them one at a time. It then sends a same-bit post and clear in one cycle, followed by a lone clear, which shows that only that bit was pending. An out-of-range index on a legal level checks that the command is not truncated into a real bit.

// File: rtl/irq_level_pkg.sv
// Package irq_level_pkg
// Holds the shared type of the output stage's per-cycle decision.
// Assumes nothing beyond IEEE 1800-2017.
package irq_level_pkg;

    typedef enum logic [1:0] {
        DEC_IDLE = 2'd0,   // nothing above the current level
        DEC_TAKE = 2'd1,   // raise an interrupt, load summary and ID
        DEC_AST  = 2'd2    // unsupported trap request seen
    } irq_decision_e;

endpackage

// File: rtl/irq_pending_store.sv
// Module irq_pending_store
// Holds one SRC_W-bit pending vector per level plus a per-level status bit.
// Applies post, clear and clear-all commands. clear-all overrides the other
// two, and post overrides clear on the same bit. Out-of-range commands are
// dropped and flagged with a one-cycle error pulse.
// Assumes a synchronous active-low reset.
module irq_pending_store #(
    parameter int NUM_LEVELS = 32,
    parameter int SRC_W      = 64,
    parameter int LVL_AW     = $clog2(NUM_LEVELS) + 1,
    parameter int IDX_AW     = $clog2(SRC_W) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  post_v,
    input  logic [LVL_AW-1:0]     post_lvl,
    input  logic [IDX_AW-1:0]     post_idx,
    input  logic                  clr_v,
    input  logic [LVL_AW-1:0]     clr_lvl,
    input  logic [IDX_AW-1:0]     clr_idx,
    input  logic                  clr_all,
    output logic [NUM_LEVELS-1:0] status,
    output logic                  cmd_err
);

    localparam logic [LVL_AW-1:0] LVL_LIMIT = LVL_AW'(NUM_LEVELS);
    localparam logic [IDX_AW-1:0] IDX_LIMIT = IDX_AW'(SRC_W);

    logic post_ok;
    logic clr_ok;
    logic [SRC_W-1:0] vec [NUM_LEVELS];

    // Range check of both command ports.
    always_comb begin
        post_ok = post_v && (post_lvl < LVL_LIMIT) && (post_idx < IDX_LIMIT);
        clr_ok  = clr_v  && (clr_lvl  < LVL_LIMIT) && (clr_idx  < IDX_LIMIT);
    end

    // Error pulse for any illegal command.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_err <= 1'b0;
        else        cmd_err <= (post_v && !post_ok) || (clr_v && !clr_ok);
    end

    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_level
        logic             set_hit;
        logic             clr_hit;
        logic [SRC_W-1:0] set_mask;
        logic [SRC_W-1:0] clr_mask;
        logic [SRC_W-1:0] vec_nxt;

        // Masks for this level; the post mask is applied last so it wins.
        always_comb begin
            set_hit  = post_ok && (post_lvl == LVL_AW'(l));
            clr_hit  = clr_ok  && (clr_lvl  == LVL_AW'(l));
            set_mask = set_hit ? (SRC_W'(1) << post_idx) : '0;
            clr_mask = clr_hit ? (SRC_W'(1) << clr_idx)  : '0;
            vec_nxt  = (vec[l] & ~clr_mask) | set_mask;
        end

        // Sub-source vector of this level.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) vec[l] <= '0;
            else                   vec[l] <= vec_nxt;
        end

        // Level status: set by a post, dropped only when a clear empties it.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) status[l] <= 1'b0;
            else if (set_hit)      status[l] <= 1'b1;
            else if (clr_hit)      status[l] <= |vec_nxt;
        end

        // R2
        status_matches_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
            status[l] == (|vec[l]));
    end

    // R3
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (status == '0));

    // R4
    bad_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((post_v && !post_ok) || (clr_v && !clr_ok)) |=> cmd_err);

    // R10
    post_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post_ok && !clr_all) |=> (status != '0));

endmodule

// File: rtl/irq_prio_resolve.sv
// Module irq_prio_resolve
// Combinational mapping of software requests and external level status into
// one priority space. Both ranges are scanned from low to high, software
// first, and the last hit wins. Every contributing bit goes into the summary.
// Assumes SW_LO <= SW_HI < EXT_LO <= EXT_HI < NUM_LEVELS.
module irq_prio_resolve #(
    parameter int NUM_LEVELS = 32,
    parameter int SW_LO      = 1,
    parameter int SW_HI      = 15,
    parameter int EXT_LO     = 16,
    parameter int EXT_HI     = 31,
    parameter int PRIO_W     = $clog2(NUM_LEVELS)
) (
    input  logic [NUM_LEVELS-1:0] sw_req,
    input  logic [NUM_LEVELS-1:0] ext_status,
    output logic [PRIO_W-1:0]     prio,
    output logic [NUM_LEVELS-1:0] summary
);

    // Ordered scan: software range, then external range.
    always_comb begin
        prio    = '0;
        summary = '0;
        for (int i = SW_LO; i <= SW_HI; i++) begin
            if (sw_req[i]) begin
                prio       = PRIO_W'(i - SW_LO + 1);
                summary[i] = 1'b1;
            end
        end
        for (int i = EXT_LO; i <= EXT_HI; i++) begin
            if (ext_status[i]) begin
                prio       = PRIO_W'(i);
                summary[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_level_resolver.sv
// Module irq_level_resolver (top)
// Pending store, priority resolution and a registered output stage. The take
// pulse, the summary register and the ID register update on one edge, one
// cycle after the pending state and the request inputs they depend on.
// Assumes a synchronous active-low reset and a single clock.
module irq_level_resolver
    import irq_level_pkg::*;
#(
    parameter int NUM_LEVELS = 32,
    parameter int SRC_W      = 64,
    parameter int SW_LO      = 1,
    parameter int SW_HI      = 15,
    parameter int EXT_LO     = 16,
    parameter int EXT_HI     = 31,
    parameter int AST_W      = 4,
    localparam int LVL_AW    = $clog2(NUM_LEVELS) + 1,
    localparam int IDX_AW    = $clog2(SRC_W) + 1,
    localparam int PRIO_W    = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  post_v,
    input  logic [LVL_AW-1:0]     post_lvl,
    input  logic [IDX_AW-1:0]     post_idx,
    input  logic                  clr_v,
    input  logic [LVL_AW-1:0]     clr_lvl,
    input  logic [IDX_AW-1:0]     clr_idx,
    input  logic                  clr_all,
    input  logic [NUM_LEVELS-1:0] sw_req,
    input  logic [PRIO_W-1:0]     cur_ipl,
    input  logic [AST_W-1:0]      ast_req,
    output logic [NUM_LEVELS-1:0] level_status,
    output logic                  irq_taken,
    output logic [NUM_LEVELS-1:0] isr_q,
    output logic [PRIO_W-1:0]     intid_q,
    output logic                  cmd_err,
    output logic                  ast_err
);

    logic [PRIO_W-1:0]     res_prio;
    logic [NUM_LEVELS-1:0] res_summary;
    irq_decision_e         decision;

    irq_pending_store #(
        .NUM_LEVELS (NUM_LEVELS),
        .SRC_W      (SRC_W),
        .LVL_AW     (LVL_AW),
        .IDX_AW     (IDX_AW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .post_v   (post_v),
        .post_lvl (post_lvl),
        .post_idx (post_idx),
        .clr_v    (clr_v),
        .clr_lvl  (clr_lvl),
        .clr_idx  (clr_idx),
        .clr_all  (clr_all),
        .status   (level_status),
        .cmd_err  (cmd_err)
    );

    irq_prio_resolve #(
        .NUM_LEVELS (NUM_LEVELS),
        .SW_LO      (SW_LO),
        .SW_HI      (SW_HI),
        .EXT_LO     (EXT_LO),
        .EXT_HI     (EXT_HI),
        .PRIO_W     (PRIO_W)
    ) u_resolve (
        .sw_req     (sw_req),
        .ext_status (level_status),
        .prio       (res_prio),
        .summary    (res_summary)
    );

    // Per-cycle decision: trap error first, then the priority comparison.
    always_comb begin
        if (ast_req != '0)
            decision = DEC_AST;
        else if ((res_prio != '0) && (res_prio > cur_ipl))
            decision = DEC_TAKE;
        else
            decision = DEC_IDLE;
    end

    // Output stage: pulse, summary and ID registers load on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_taken <= 1'b0;
            ast_err   <= 1'b0;
            isr_q     <= '0;
            intid_q   <= '0;
        end else begin
            irq_taken <= (decision == DEC_TAKE);
            ast_err   <= (decision == DEC_AST);
            if (decision == DEC_TAKE) begin
                isr_q   <= res_summary;
                intid_q <= res_prio;
            end
        end
    end

    // R8
    take_above_ipl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |-> ((intid_q != '0) && (intid_q > $past(cur_ipl))));

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_taken |-> ($stable(isr_q) && $stable(intid_q)));

    // R9
    ast_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ast_req != '0) |=> (ast_err && !irq_taken));

    // R9
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ast_err && irq_taken));

endmodule

// File: tb/irq_level_resolver_tb.sv
module irq_level_resolver_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NROWS      = 12;

    typedef struct packed {
        logic [31:0] sw;
        logic [31:0] ext;
        logic [4:0]  ipl;
        logic        take;
        logic [4:0]  id;
        logic [31:0] isr;
    } row_t;

    // R5 R6 R7 R8: software mapping, external mapping, ordering, compare
    localparam row_t ROWS [NROWS] = '{
        '{32'h0000_0000, 32'h0000_0000, 5'd0,  1'b0, 5'd0,  32'h0000_0000},
        '{32'h0000_0008, 32'h0000_0000, 5'd0,  1'b1, 5'd3,  32'h0000_0008},
        '{32'h0000_0408, 32'h0000_0000, 5'd5,  1'b1, 5'd10, 32'h0000_0408},
        '{32'h0000_0408, 32'h0000_0000, 5'd10, 1'b0, 5'd0,  32'h0000_0000},
        '{32'h0000_8000, 32'h0010_0000, 5'd0,  1'b1, 5'd20, 32'h0010_8000},
        '{32'h0000_0000, 32'h4002_0000, 5'd29, 1'b1, 5'd30, 32'h4002_0000},
        '{32'h0000_0000, 32'h8000_0000, 5'd31, 1'b0, 5'd0,  32'h0000_0000},
        '{32'h0001_0001, 32'h0000_0000, 5'd0,  1'b0, 5'd0,  32'h0000_0000},
        '{32'h0000_0000, 32'h0000_0020, 5'd0,  1'b0, 5'd0,  32'h0000_0000},
        '{32'h0000_0004, 32'h0000_0020, 5'd0,  1'b1, 5'd2,  32'h0000_0004},
        '{32'h0000_7FFE, 32'h8001_0000, 5'd20, 1'b1, 5'd31, 32'h8001_7FFE},
        '{32'h0000_0000, 32'h0001_0000, 5'd15, 1'b1, 5'd16, 32'h0001_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        post_v, clr_v, clr_all;
    logic [5:0]  post_lvl, clr_lvl;
    logic [6:0]  post_idx, clr_idx;
    logic [31:0] sw_req;
    logic [4:0]  cur_ipl;
    logic [3:0]  ast_req;
    logic [31:0] level_status, isr_q;
    logic        irq_taken, cmd_err, ast_err;
    logic [4:0]  intid_q;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_level_resolver u_dut (
        .clk(clk), .rst_n(rst_n),
        .post_v(post_v), .post_lvl(post_lvl), .post_idx(post_idx),
        .clr_v(clr_v), .clr_lvl(clr_lvl), .clr_idx(clr_idx),
        .clr_all(clr_all), .sw_req(sw_req), .cur_ipl(cur_ipl),
        .ast_req(ast_req), .level_status(level_status),
        .irq_taken(irq_taken), .isr_q(isr_q), .intid_q(intid_q),
        .cmd_err(cmd_err), .ast_err(ast_err)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One-cycle command; on return the edge has applied it.
    task automatic cmd(input logic pv, input int pl, input int pi,
                       input logic cv, input int cl, input int ci, input logic ca);
        @(negedge clk);
        post_v = pv; post_lvl = 6'(pl); post_idx = 7'(pi);
        clr_v  = cv; clr_lvl  = 6'(cl); clr_idx  = 7'(ci);
        clr_all = ca;
        @(negedge clk);
        post_v = 1'b0; clr_v = 1'b0; clr_all = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; post_v = 0; clr_v = 0; clr_all = 0;
        post_lvl = 0; post_idx = 0; clr_lvl = 0; clr_idx = 0;
        sw_req = 0; cur_ipl = 5'd31; ast_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state
        check("R3 status", level_status, 32'h0);
        check("R3 irq", {31'h0, irq_taken}, 32'h0);
        check("R3 isr", isr_q, 32'h0);
        check("R3 intid", {27'h0, intid_q}, 32'h0);
        check("R3 errs", {30'h0, cmd_err, ast_err}, 32'h0);

        // Table walk
        for (int r = 0; r < NROWS; r++) begin
            sw_req = 0; cur_ipl = 5'd31;
            cmd(0, 0, 0, 0, 0, 0, 1);
            for (int l = 0; l < 32; l++)
                if (ROWS[r].ext[l]) cmd(1, l, 3, 0, 0, 0, 0);
            // R1 posted levels visible in the status word
            check("R1 status", level_status, ROWS[r].ext);
            @(negedge clk);
            sw_req = ROWS[r].sw; cur_ipl = ROWS[r].ipl;
            @(negedge clk);
            check("R8 irq_taken", {31'h0, irq_taken}, {31'h0, ROWS[r].take});
            if (ROWS[r].take) begin
                check("R7 intid", {27'h0, intid_q}, {27'h0, ROWS[r].id});
                check("R5 R6 isr", isr_q, ROWS[r].isr);
            end
        end

        // R8 hold: last row loaded id 16; raise ipl so nothing is taken
        cur_ipl = 5'd31; sw_req = 32'h0000_0002;
        @(negedge clk); @(negedge clk);
        check("R8 idle irq", {31'h0, irq_taken}, 32'h0);
        check("R8 hold intid", {27'h0, intid_q}, 32'd16);
        check("R8 hold isr", isr_q, 32'h0001_0000);
        sw_req = 0;

        // R2 partial clear keeps the level pending
        cmd(0, 0, 0, 0, 0, 0, 1);
        cmd(1, 20, 1, 0, 0, 0, 0);
        cmd(1, 20, 40, 0, 0, 0, 0);
        cmd(0, 0, 0, 1, 20, 1, 0);
        check("R2 partial", level_status, 32'h0010_0000);
        cmd(0, 0, 0, 1, 20, 40, 0);
        check("R2 empty", level_status, 32'h0);

        // R10 post and clear of the same bit
        cmd(1, 22, 7, 1, 22, 7, 0);
        check("R10 post wins", level_status, 32'h0040_0000);
        cmd(0, 0, 0, 1, 22, 7, 0);
        check("R10 lone clear", level_status, 32'h0);

        // R4 out-of-range index and level
        cmd(1, 20, 0, 0, 0, 0, 0);
        check("R4 no err", {31'h0, cmd_err}, 32'h0);
        cmd(0, 0, 0, 1, 20, 64, 0);
        check("R4 err idx", {31'h0, cmd_err}, 32'h1);
        check("R4 state idx", level_status, 32'h0010_0000);
        @(negedge clk);
        check("R4 pulse ends", {31'h0, cmd_err}, 32'h0);
        cmd(1, 32, 0, 0, 0, 0, 0);
        check("R4 err lvl", {31'h0, cmd_err}, 32'h1);
        check("R4 state lvl", level_status, 32'h0010_0000);

        // R3 clear-all beats a post in the same cycle
        cmd(1, 25, 0, 0, 0, 0, 1);
        check("R3 clr_all wins", level_status, 32'h0);

        // R9 trap request blocks resolution
        @(negedge clk);
        sw_req = 32'h0000_0020; cur_ipl = 5'd0; ast_req = 4'h2;
        @(negedge clk);
        check("R9 ast_err", {31'h0, ast_err}, 32'h1);
        check("R9 no irq", {31'h0, irq_taken}, 32'h0);
        ast_req = 4'h0;
        @(negedge clk);
        check("R9 resume irq", {31'h0, irq_taken}, 32'h1);
        check("R9 resume id", {27'h0, intid_q}, 32'd5);
        sw_req = 0; cur_ipl = 5'd31;

        // R3 reset mid-run
        cmd(1, 18, 2, 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R3 reset status", level_status, 32'h0);
        check("R3 reset intid", {27'h0, intid_q}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule